// File: doc/BRIEF.md
# Burst Preamble Detector and Reset Timing Checker

The block watches a retimed serial bit stream at one sample per unit interval (UI), marked by a clock enable. It finds the alternating, maximum-transition-density part of a burst preamble. When enough consecutive alternating bits have been seen, it raises a phase-acquired flag. That flag stays up until the burst is declared over or the between-burst RESET arrives. RESET re-arms the block for fast acquisition on the next burst. Only the digital recognition and timing checks are modelled; the analog loops are not.

A companion checker measures the between-burst RESET against three UI-counted windows. The first window is from the burst-end indication to the assertion of RESET. The second is the width of the RESET pulse. The third is whether RESET is still held when an alternating preamble run completes. Each violation sets its own sticky flag. Every flag clears on the next RESET assertion.

The acquisition machine has three states. `ACQ_ARMED` goes to `ACQ_LOCKED` when the pattern is found, and goes to `ACQ_SPENT` on a burst end. `ACQ_LOCKED` goes to `ACQ_ARMED` on RESET, and to `ACQ_SPENT` on a burst end. `ACQ_SPENT` goes to `ACQ_ARMED` on RESET. The checker machine also has three states. `CHK_LIVE` goes to `CHK_GAP` on a burst end, and to `CHK_PULSE` on a RESET rise. `CHK_GAP` goes to `CHK_PULSE` when RESET rises. `CHK_PULSE` goes to `CHK_LIVE` when RESET is released.

Top module: `burst_preamble_monitor`

## Requirements
- R1: While `rst_n` is low, every output is 0, the acquisition machine is armed and the checker is in `CHK_LIVE`.
- R2: The alternating-run length is counted on each UI sample. It is 1 for the first sample, 1 again when `bit_in` equals the previous sampled bit, and otherwise grows by one, saturating at `ALT_LEN` (default 8). When the armed machine sees a run of `ALT_LEN` at a UI sample where `rx_reset` and `burst_end` are low, `acquired` rises after that sample. With the default setting, this is at the UI following the 8th alternating bit, well within 12 UI of the pattern start. A run shorter than `ALT_LEN` never raises it.
- R3: `acquired` stays high until a UI sample with `rx_reset` or `burst_end` high. A `burst_end` sample clears it and disarms detection until RESET.
- R4: A UI sample with `rx_reset` high clears `acquired` and re-arms detection.
- R5: After a UI sample with `burst_end` high, RESET must rise within the next `ASSERT_WIN` (default 8) UI samples. `late_assert_err` rises at the `ASSERT_WIN`-th sample without RESET. At the assertion sample it is reloaded to 1 when that sample came after the window, and to 0 otherwise.
- R6: `short_pulse_err` rises at the release sample when RESET was high for fewer than `MIN_WIDTH` (default 16) consecutive UI samples.
- R7: `late_release_err` rises at a UI sample where `rx_reset` is high and a completed alternating run of `ALT_LEN` bits is present.
- R8: The violation flags are sticky. The UI sample on which `rx_reset` rises from low clears `short_pulse_err` and `late_release_err`, and sets `late_assert_err` as R5 gives.
- R9: UI samples are taken only where `ui_en` is high. With `ui_en` low, no output or internal state changes, whatever `bit_in`, `rx_reset` and `burst_end` do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| ui_en | input | 1 | One-cycle enable marking each unit-interval sample |
| bit_in | input | 1 | Retimed data bit for this UI |
| rx_reset | input | 1 | Between-burst RESET, active high |
| burst_end | input | 1 | Marks the UI at which the current burst ended |
| acquired | output | 1 | Phase-acquired flag |
| late_assert_err | output | 1 | RESET came too late after burst end (sticky) |
| short_pulse_err | output | 1 | RESET pulse shorter than the minimum (sticky) |
| late_release_err | output | 1 | RESET still held when a preamble run completed (sticky) |

## Verification
The assertions take for granted that `ALT_LEN` is at least 2. They also assume that `burst_end` is a one-UI marker driven only while RESET is low, so the checker never sees an end inside a pulse. The stimulus drives every input at the falling edge and holds `burst_end` for exactly one sample. Sweeps sit on both sides of each window: run lengths 1 to 12, gaps 1 to 12 UI, and pulse widths 12 to 20 UI. Enable gaps are inserted with conflicting inputs, to show that only enabled samples count.

// File: rtl/bpm_pkg.sv
package bpm_pkg;

    typedef enum logic [1:0] {
        ACQ_ARMED  = 2'd0,
        ACQ_LOCKED = 2'd1,
        ACQ_SPENT  = 2'd2
    } acq_state_t;

    typedef enum logic [1:0] {
        CHK_LIVE  = 2'd0,
        CHK_GAP   = 2'd1,
        CHK_PULSE = 2'd2
    } chk_state_t;

endpackage

// File: rtl/bpm_alt_run.sv
module bpm_alt_run #(
    parameter int ALT_LEN = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ui_en,
    input  logic bit_in,
    output logic pattern_seen
);
    localparam int RW = $clog2(ALT_LEN + 1);
    localparam logic [RW-1:0] RUN_MAX = RW'(ALT_LEN);
    localparam logic [RW-1:0] RUN_ONE = RW'(1);

    logic [RW-1:0] run_q;
    logic          prev_bit;
    logic          have_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q     <= '0;
            prev_bit  <= 1'b0;
            have_prev <= 1'b0;
        end else if (ui_en) begin
            have_prev <= 1'b1;
            prev_bit  <= bit_in;
            if (!have_prev || bit_in == prev_bit)
                run_q <= RUN_ONE;
            else if (run_q != RUN_MAX)
                run_q <= run_q + RUN_ONE;
        end
    end

    assign pattern_seen = (run_q == RUN_MAX);

    // R2
    no_false_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ui_en && have_prev && (bit_in == prev_bit) |=> !pattern_seen);

endmodule

// File: rtl/bpm_acq_fsm.sv
module bpm_acq_fsm
    import bpm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ui_en,
    input  logic rx_reset,
    input  logic burst_end,
    input  logic pattern_seen,
    output logic acquired
);
    acq_state_t state_q, state_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ACQ_ARMED;
        else        state_q <= state_n;
    end

    always_comb begin
        state_n = state_q;
        if (ui_en) begin
            unique case (state_q)
                ACQ_ARMED: begin
                    if (rx_reset)          state_n = ACQ_ARMED;
                    else if (burst_end)    state_n = ACQ_SPENT;
                    else if (pattern_seen) state_n = ACQ_LOCKED;
                end
                ACQ_LOCKED: begin
                    if (rx_reset)          state_n = ACQ_ARMED;
                    else if (burst_end)    state_n = ACQ_SPENT;
                end
                ACQ_SPENT: begin
                    if (rx_reset)          state_n = ACQ_ARMED;
                end
                default:                   state_n = ACQ_ARMED;
            endcase
        end
    end

    always_comb begin
        acquired = (state_q == ACQ_LOCKED);
    end

    // R2
    acquire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ui_en && state_q == ACQ_ARMED && pattern_seen && !rx_reset && !burst_end
        |=> acquired);

    // R4
    reset_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ui_en && rx_reset |=> !acquired && state_q == ACQ_ARMED);

    // R3
    burst_end_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ui_en && burst_end && !rx_reset |=> !acquired);

    // R9
    acq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ui_en |=> $stable(acquired));

endmodule

// File: rtl/bpm_reset_chk.sv
module bpm_reset_chk
    import bpm_pkg::*;
#(
    parameter int ASSERT_WIN = 8,
    parameter int MIN_WIDTH  = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ui_en,
    input  logic rx_reset,
    input  logic burst_end,
    input  logic pattern_seen,
    output logic late_assert_err,
    output logic short_pulse_err,
    output logic late_release_err
);
    localparam int GW = $clog2(ASSERT_WIN + 1);
    localparam int WW = $clog2(MIN_WIDTH + 1);
    localparam logic [GW-1:0] GAP_MAX  = GW'(ASSERT_WIN);
    localparam logic [GW-1:0] GAP_LAST = GW'(ASSERT_WIN - 1);
    localparam logic [WW-1:0] WID_MAX  = WW'(MIN_WIDTH);

    chk_state_t    state_q, state_n;
    logic [GW-1:0] gap_q, gap_n;
    logic [WW-1:0] wid_q, wid_n;
    logic          la_q, la_n, sp_q, sp_n, lr_q, lr_n;
    logic          rst_prev_q;
    logic          rise;

    assign rise = ui_en && rx_reset && !rst_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= CHK_LIVE;
            gap_q      <= '0;
            wid_q      <= '0;
            la_q       <= 1'b0;
            sp_q       <= 1'b0;
            lr_q       <= 1'b0;
            rst_prev_q <= 1'b0;
        end else begin
            state_q <= state_n;
            gap_q   <= gap_n;
            wid_q   <= wid_n;
            la_q    <= la_n;
            sp_q    <= sp_n;
            lr_q    <= lr_n;
            if (ui_en) rst_prev_q <= rx_reset;
        end
    end

    always_comb begin
        state_n = state_q;
        gap_n   = gap_q;
        wid_n   = wid_q;
        la_n    = la_q;
        sp_n    = sp_q;
        lr_n    = lr_q;
        if (ui_en) begin
            unique case (state_q)
                CHK_LIVE: begin
                    if (rise) begin
                        la_n    = 1'b0;
                        sp_n    = 1'b0;
                        lr_n    = 1'b0;
                        wid_n   = WW'(1);
                        state_n = CHK_PULSE;
                    end else if (burst_end) begin
                        gap_n   = '0;
                        state_n = CHK_GAP;
                    end
                end
                CHK_GAP: begin
                    if (rx_reset) begin
                        la_n    = (gap_q >= GAP_MAX);
                        sp_n    = 1'b0;
                        lr_n    = 1'b0;
                        wid_n   = WW'(1);
                        state_n = CHK_PULSE;
                    end else begin
                        if (gap_q != GAP_MAX) gap_n = gap_q + GW'(1);
                        if (gap_q == GAP_LAST) la_n = 1'b1;
                    end
                end
                CHK_PULSE: begin
                    if (rx_reset) begin
                        if (wid_q != WID_MAX) wid_n = wid_q + WW'(1);
                        if (pattern_seen)     lr_n  = 1'b1;
                    end else begin
                        if (wid_q < WID_MAX)  sp_n  = 1'b1;
                        state_n = CHK_LIVE;
                    end
                end
                default: state_n = CHK_LIVE;
            endcase
        end
    end

    always_comb begin
        late_assert_err  = la_q;
        short_pulse_err  = sp_q;
        late_release_err = lr_q;
    end

    // R8
    clear_on_assert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !short_pulse_err && !late_release_err);

    // R6
    short_at_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(short_pulse_err) |-> $past(ui_en && !rx_reset));

    // R5
    timely_assert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ui_en && state_q == CHK_GAP && rx_reset && gap_q < GAP_MAX |=> !late_assert_err);

    // R9
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ui_en |=> $stable({late_assert_err, short_pulse_err, late_release_err}));

endmodule

// File: rtl/burst_preamble_monitor.sv
module burst_preamble_monitor #(
    parameter int ALT_LEN    = 8,
    parameter int ASSERT_WIN = 8,
    parameter int MIN_WIDTH  = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ui_en,
    input  logic bit_in,
    input  logic rx_reset,
    input  logic burst_end,
    output logic acquired,
    output logic late_assert_err,
    output logic short_pulse_err,
    output logic late_release_err
);
    logic pattern_seen;

    bpm_alt_run #(.ALT_LEN(ALT_LEN)) u_run (
        .clk          (clk),
        .rst_n        (rst_n),
        .ui_en        (ui_en),
        .bit_in       (bit_in),
        .pattern_seen (pattern_seen)
    );

    bpm_acq_fsm u_acq (
        .clk          (clk),
        .rst_n        (rst_n),
        .ui_en        (ui_en),
        .rx_reset     (rx_reset),
        .burst_end    (burst_end),
        .pattern_seen (pattern_seen),
        .acquired     (acquired)
    );

    bpm_reset_chk #(.ASSERT_WIN(ASSERT_WIN), .MIN_WIDTH(MIN_WIDTH)) u_chk (
        .clk              (clk),
        .rst_n            (rst_n),
        .ui_en            (ui_en),
        .rx_reset         (rx_reset),
        .burst_end        (burst_end),
        .pattern_seen     (pattern_seen),
        .late_assert_err  (late_assert_err),
        .short_pulse_err  (short_pulse_err),
        .late_release_err (late_release_err)
    );

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !acquired && !late_assert_err && !short_pulse_err && !late_release_err);

endmodule

// File: tb/burst_preamble_monitor_test.sv
`timescale 1ns/1ps
module burst_preamble_monitor_test;
    localparam int ALT  = 8;
    localparam int WIN  = 8;
    localparam int MINW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ui_en = 1'b0;
    logic bit_in = 1'b1;
    logic rx_reset = 1'b0;
    logic burst_end = 1'b0;
    logic acquired, late_assert_err, short_pulse_err, late_release_err;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    burst_preamble_monitor #(.ALT_LEN(ALT), .ASSERT_WIN(WIN), .MIN_WIDTH(MINW)) uut (
        .clk(clk), .rst_n(rst_n), .ui_en(ui_en), .bit_in(bit_in),
        .rx_reset(rx_reset), .burst_end(burst_end), .acquired(acquired),
        .late_assert_err(late_assert_err), .short_pulse_err(short_pulse_err),
        .late_release_err(late_release_err)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic step(input logic b, input logic r, input logic e);
        @(negedge clk);
        ui_en = 1'b1; bit_in = b; rx_reset = r; burst_end = e;
        @(posedge clk);
        #1;
    endtask

    task automatic idle_step(input logic b, input logic r, input logic e);
        @(negedge clk);
        ui_en = 1'b0; bit_in = b; rx_reset = r; burst_end = e;
        @(posedge clk);
        #1;
    endtask

    task automatic rearm();
        repeat (MINW) step(1'b1, 1'b1, 1'b0);
        repeat (3) step(1'b1, 1'b0, 1'b0);
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 acquired", acquired, 1'b0);
        check("R1 late_assert", late_assert_err, 1'b0);
        check("R1 short_pulse", short_pulse_err, 1'b0);
        check("R1 late_release", late_release_err, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2 / R3: sweep alternating run lengths 1..12
        for (int n = 1; n <= 12; n++) begin
            logic last;
            rearm();
            for (int i = 0; i < n; i++) step((i % 2 == 0), 1'b0, 1'b0);
            check($sformatf("R2 before n=%0d", n), acquired, n >= ALT + 1);
            last = ((n - 1) % 2 == 0);
            step(last, 1'b0, 1'b0);
            check($sformatf("R2 after n=%0d", n), acquired, n >= ALT);
            repeat (2) step(last, 1'b0, 1'b0);
            check($sformatf("R3 held n=%0d", n), acquired, n >= ALT);
        end

        // R3: burst end drops and disarms
        step(1'b1, 1'b0, 1'b1);
        check("R3 burst_end clears", acquired, 1'b0);
        for (int i = 0; i < 12; i++) step((i % 2 == 0), 1'b0, 1'b0);
        check("R3 spent ignores pattern", acquired, 1'b0);

        // R9: enable gaps with conflicting bits are ignored
        rearm();
        for (int i = 0; i < ALT + 1; i++) begin
            step((i % 2 == 0), 1'b0, 1'b0);
            idle_step(!(i % 2 == 0), 1'b0, 1'b0);
        end
        check("R9 gapped pattern acquires", acquired, 1'b1);
        repeat (5) idle_step(1'b0, 1'b1, 1'b1);
        check("R9 disabled reset ignored", acquired, 1'b1);
        // R4
        step(1'b1, 1'b1, 1'b0);
        check("R4 reset clears acquired", acquired, 1'b0);
        repeat (MINW) step(1'b1, 1'b1, 1'b0);
        step(1'b1, 1'b0, 1'b0);

        // R5: gap sweep 1..12 UI
        for (int d = 1; d <= 12; d++) begin
            step(1'b1, 1'b0, 1'b1);
            for (int k = 1; k < d; k++) begin
                step(1'b1, 1'b0, 1'b0);
                if (k == WIN) check($sformatf("R5 window expiry d=%0d", d), late_assert_err, 1'b1);
            end
            step(1'b1, 1'b1, 1'b0);
            check($sformatf("R5 assert d=%0d", d), late_assert_err, d > WIN);
            repeat (MINW - 1) step(1'b1, 1'b1, 1'b0);
            step(1'b1, 1'b0, 1'b0);
            check($sformatf("R6 full pulse d=%0d", d), short_pulse_err, 1'b0);
        end

        // R6 / R8: pulse width sweep 12..20 UI
        for (int w = 12; w <= 20; w++) begin
            step(1'b1, 1'b1, 1'b0);
            check($sformatf("R8 short cleared w=%0d", w), short_pulse_err, 1'b0);
            check($sformatf("R8 late cleared w=%0d", w), late_assert_err, 1'b0);
            repeat (w - 1) step(1'b1, 1'b1, 1'b0);
            step(1'b1, 1'b0, 1'b0);
            check($sformatf("R6 width w=%0d", w), short_pulse_err, w < MINW);
            step(1'b1, 1'b0, 1'b0);
        end

        // R7: preamble run completes while RESET held
        repeat (6) step(1'b1, 1'b1, 1'b0);
        for (int i = 0; i < 10; i++) step((i % 2 == 0), 1'b1, 1'b0);
        check("R7 late release flagged", late_release_err, 1'b1);
        repeat (2) step(1'b0, 1'b1, 1'b0);
        repeat (MINW) step(1'b0, 1'b1, 1'b0);
        step(1'b0, 1'b0, 1'b0);
        check("R7 sticky after release", late_release_err, 1'b1);
        check("R7 no acquire from stale run", acquired, 1'b0);
        step(1'b1, 1'b1, 1'b0);
        check("R8 late release cleared", late_release_err, 1'b0);
        for (int i = 0; i < ALT - 1; i++) step((i % 2 == 0), 1'b1, 1'b0);
        repeat (MINW) step(1'b1, 1'b1, 1'b0);
        check("R7 short run not flagged", late_release_err, 1'b0);
        step(1'b1, 1'b0, 1'b0);
        check("R6 long pulse ok", short_pulse_err, 1'b0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule